// File: doc/BRIEF.md
# Two-Level Masked Interrupt Collector

This block gathers single-bit event lines from the analog and housekeeping parts of a power-management device and reduces them to one active-high interrupt request. The sources are split into banks of equal width. The default is three banks of eight, which gives 24 sources. Source `n` belongs to bank `n / BANK_W` at bit `n % BANK_W`.

Each source passes through two separate masks:

- The **capture mask** decides whether a rising edge on the source is recorded in its sticky status bit.
- The **line mask** decides only whether a recorded status bit may drive the interrupt output.

A source that is capture-masked can never raise the output, whatever its line-mask bit is set to.

A byte-wide register port with a combinational read path gives access to every status and mask register. Software clears status bits by writing ones to them.

Top module: `evt_irq_hub`

## Requirements
- R1: After reset, every status bit reads 0, every line-mask and capture-mask bit reads 1, and `irq_out` is 0.
- R2: The register map is as follows. Status of banks 0, 1, 2 sits at addresses 0, 1, 2. Line masks of banks 0, 1, 2 sit at addresses 3, 4, 5. Capture masks of banks 0, 1, 2 sit at addresses 6, 7, 8. Bit `i` of bank `b` belongs to source `8*b+i`. Any other address reads 0x00.
- R3: A rising edge on a source whose capture-mask bit is 1 leaves its status bit unchanged.
- R4: A rising edge on a source whose capture-mask bit is 0 sets its status bit, whatever its line-mask bit is.
- R5: A set status bit whose line-mask bit is 1 does not assert `irq_out`.
- R6: `irq_out` is a register. It goes to 1 one clock after some source has status 1, line mask 0 and capture mask 0 all at once; otherwise it is 0. Setting the capture-mask bit of a latched source removes that source's contribution.
- R7: Writing a 1 to a status bit clears it. Writing a 0 leaves it unchanged.
- R8: If a rising edge and a clearing write hit the same status bit in the same cycle, the bit stays set.
- R9: Only the low-to-high transition of a source is recorded. A source held high does not set its status bit again after a clear.
- R10: Writes to unmapped addresses change no register, and writes to a status address never set a status bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| evt_in | input | 24 | Event source lines, source n at bit n |
| wr_en | input | 1 | Register write strobe for this cycle |
| addr | input | 4 | Register address for read and write |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| irq_out | output | 1 | Registered, level, active-high interrupt request |

## Verification
The bench targets the cases where the two mask layers interact:

- **Capture-masking after a bit is latched.** A design that gated the output with the line mask alone would keep the interrupt asserted here.
- **A rising edge and a clearing write on the same bit in the same cycle.** A design that gave the clear priority would lose that event.
- **A source held high across a clear.** A level-sensitive design would set the bit again at once.
- **Sources at the first and last bit of different banks, and writes of zeros or unmapped addresses.** These expose swapped bank offsets, a status that can be set by software, and stray decode hits.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;

   // Which register group an address falls into.
   typedef enum logic [1:0] {
      RK_NONE      = 2'd0,
      RK_STATUS    = 2'd1,
      RK_LINE_MASK = 2'd2,
      RK_CAPT_MASK = 2'd3
   } reg_kind_e;

   // Number of register groups, each holding one register per bank.
   localparam int unsigned REG_GROUPS = 3;

endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det #(
   parameter int unsigned WIDTH = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] lvl_in,
   output logic [WIDTH-1:0] rise_out
);

   generate
      if (WIDTH < 1) begin : g_bad_width
         $error("evt_edge_det: WIDTH must be at least 1");
      end
   endgenerate

   logic [WIDTH-1:0] lvl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= '0;
      else        lvl_d <= lvl_in;
   end

   assign rise_out = lvl_in & ~lvl_d;

endmodule

// File: rtl/evt_irq_bank.sv
module evt_irq_bank #(
   parameter int unsigned BANK_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [BANK_W-1:0] rise,
   input  logic              sts_we,
   input  logic              lmsk_we,
   input  logic              cmsk_we,
   input  logic [BANK_W-1:0] wdata,
   output logic [BANK_W-1:0] sts_q,
   output logic [BANK_W-1:0] lmsk_q,
   output logic [BANK_W-1:0] cmsk_q,
   output logic              pend
);

   logic [BANK_W-1:0] clr_bits;
   logic [BANK_W-1:0] set_bits;
   logic [BANK_W-1:0] sts_d;

   // Write-one-to-clear; a captured edge in the same cycle wins.
   assign clr_bits = sts_we ? wdata : '0;
   assign set_bits = rise & ~cmsk_q;
   assign sts_d    = (sts_q & ~clr_bits) | set_bits;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sts_q  <= '0;
         lmsk_q <= '1;
         cmsk_q <= '1;
      end else begin
         sts_q <= sts_d;
         if (lmsk_we) lmsk_q <= wdata;
         if (cmsk_we) cmsk_q <= wdata;
      end
   end

   assign pend = |(sts_q & ~lmsk_q & ~cmsk_q);

endmodule

// File: rtl/evt_irq_regmux.sv
module evt_irq_regmux
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                              wr_en,
   input  logic [ADDR_W-1:0]                 addr,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  sts,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  lmsk,
   input  logic [NUM_BANKS-1:0][BANK_W-1:0]  cmsk,
   output logic [NUM_BANKS-1:0]              sts_we,
   output logic [NUM_BANKS-1:0]              lmsk_we,
   output logic [NUM_BANKS-1:0]              cmsk_we,
   output logic [BANK_W-1:0]                 rdata
);

   localparam int unsigned SEL_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;

   reg_kind_e        kind;
   logic [SEL_W-1:0] bank_sel;

   // Address decode: group base is group_index * NUM_BANKS.
   always_comb begin
      kind     = RK_NONE;
      bank_sel = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (int'(addr) == b) begin
            kind     = RK_STATUS;
            bank_sel = SEL_W'(b);
         end
         if (int'(addr) == NUM_BANKS + b) begin
            kind     = RK_LINE_MASK;
            bank_sel = SEL_W'(b);
         end
         if (int'(addr) == 2 * NUM_BANKS + b) begin
            kind     = RK_CAPT_MASK;
            bank_sel = SEL_W'(b);
         end
      end
   end

   genvar gb;
   generate
      for (gb = 0; gb < NUM_BANKS; gb++) begin : g_we
         assign sts_we[gb]  = wr_en && (kind == RK_STATUS)    && (int'(bank_sel) == gb);
         assign lmsk_we[gb] = wr_en && (kind == RK_LINE_MASK) && (int'(bank_sel) == gb);
         assign cmsk_we[gb] = wr_en && (kind == RK_CAPT_MASK) && (int'(bank_sel) == gb);
      end
   endgenerate

   always_comb begin
      unique case (kind)
         RK_STATUS:    rdata = sts[bank_sel];
         RK_LINE_MASK: rdata = lmsk[bank_sel];
         RK_CAPT_MASK: rdata = cmsk[bank_sel];
         default:      rdata = '0;
      endcase
   end

endmodule

// File: rtl/evt_irq_hub.sv
module evt_irq_hub
   import evt_irq_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic [NUM_BANKS*BANK_W-1:0]    evt_in,
   input  logic                           wr_en,
   input  logic [ADDR_W-1:0]              addr,
   input  logic [BANK_W-1:0]              wdata,
   output logic [BANK_W-1:0]              rdata,
   output logic                           irq_out
);

   localparam int unsigned NUM_SRC  = NUM_BANKS * BANK_W;
   localparam int unsigned NUM_REGS = REG_GROUPS * NUM_BANKS;

   generate
      if (NUM_BANKS < 1) begin : g_bad_banks
         $error("evt_irq_hub: NUM_BANKS must be at least 1");
      end
      if (BANK_W < 1) begin : g_bad_bw
         $error("evt_irq_hub: BANK_W must be at least 1");
      end
      if (NUM_REGS > (1 << ADDR_W)) begin : g_bad_aw
         $error("evt_irq_hub: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic [NUM_SRC-1:0]                   rise_all;
   logic [NUM_BANKS-1:0][BANK_W-1:0]     sts_bk, lmsk_bk, cmsk_bk;
   logic [NUM_BANKS-1:0]                 sts_we, lmsk_we, cmsk_we;
   logic [NUM_BANKS-1:0]                 pend_bk;
   logic [NUM_SRC-1:0]                   sts_all, lmsk_all, cmsk_all;

   evt_edge_det #(.WIDTH(NUM_SRC)) u_edge (
      .clk      (clk),
      .rst_n    (rst_n),
      .lvl_in   (evt_in),
      .rise_out (rise_all)
   );

   genvar gb;
   generate
      for (gb = 0; gb < NUM_BANKS; gb++) begin : g_bank
         evt_irq_bank #(.BANK_W(BANK_W)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .rise    (rise_all[gb*BANK_W +: BANK_W]),
            .sts_we  (sts_we[gb]),
            .lmsk_we (lmsk_we[gb]),
            .cmsk_we (cmsk_we[gb]),
            .wdata   (wdata),
            .sts_q   (sts_bk[gb]),
            .lmsk_q  (lmsk_bk[gb]),
            .cmsk_q  (cmsk_bk[gb]),
            .pend    (pend_bk[gb])
         );
      end
   endgenerate

   // Flat views, also used by the bound checker.
   assign sts_all  = sts_bk;
   assign lmsk_all = lmsk_bk;
   assign cmsk_all = cmsk_bk;

   evt_irq_regmux #(
      .NUM_BANKS (NUM_BANKS),
      .BANK_W    (BANK_W),
      .ADDR_W    (ADDR_W)
   ) u_regs (
      .wr_en   (wr_en),
      .addr    (addr),
      .sts     (sts_bk),
      .lmsk    (lmsk_bk),
      .cmsk    (cmsk_bk),
      .sts_we  (sts_we),
      .lmsk_we (lmsk_we),
      .cmsk_we (cmsk_we),
      .rdata   (rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_out <= 1'b0;
      else        irq_out <= |pend_bk;
   end

endmodule

// File: rtl/evt_irq_hub_chk.sv
module evt_irq_hub_chk #(
   parameter int unsigned NUM_BANKS = 3,
   parameter int unsigned BANK_W    = 8,
   parameter int unsigned ADDR_W    = 4
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        wr_en,
   input logic [ADDR_W-1:0]           addr,
   input logic [BANK_W-1:0]           wdata,
   input logic [BANK_W-1:0]           rdata,
   input logic                        irq_out,
   input logic [NUM_BANKS*BANK_W-1:0] sts_all,
   input logic [NUM_BANKS*BANK_W-1:0] lmsk_all,
   input logic [NUM_BANKS*BANK_W-1:0] cmsk_all
);

   localparam int unsigned NS = NUM_BANKS * BANK_W;

   logic [NS-1:0] clr_req;
   logic [NS-1:0] live;

   always_comb begin
      clr_req = '0;
      for (int b = 0; b < NUM_BANKS; b++) begin
         if (wr_en && int'(addr) == b) clr_req[b*BANK_W +: BANK_W] = wdata;
      end
   end

   assign live = sts_all & ~lmsk_all & ~cmsk_all;

   a_r1_reset_state: assert property (@(posedge clk)
      !rst_n |=> (sts_all == '0 && lmsk_all == '1 && cmsk_all == '1 && !irq_out));

   a_r2_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(addr) >= 3 * NUM_BANKS) |-> (rdata == '0));

   a_r3_masked_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((sts_all & ~$past(sts_all) & $past(cmsk_all)) == '0));

   a_r7_clear_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(sts_all) & ~sts_all & ~$past(clr_req)) == '0));

   a_r5_quiet_when_none_live: assert property (@(posedge clk) disable iff (!rst_n)
      (live == '0) |=> !irq_out);

   a_r6_raise_when_live: assert property (@(posedge clk) disable iff (!rst_n)
      (live != '0) |=> irq_out);

endmodule

bind evt_irq_hub evt_irq_hub_chk #(
   .NUM_BANKS (NUM_BANKS),
   .BANK_W    (BANK_W),
   .ADDR_W    (ADDR_W)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .wr_en    (wr_en),
   .addr     (addr),
   .wdata    (wdata),
   .rdata    (rdata),
   .irq_out  (irq_out),
   .sts_all  (sts_all),
   .lmsk_all (lmsk_all),
   .cmsk_all (cmsk_all)
);

// File: tb/evt_irq_hub_test.sv
module evt_irq_hub_test;

   localparam int NB = 3;
   localparam int BW = 8;
   localparam int AW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [NB*BW-1:0] evt_in = '0;
   logic            wr_en = 1'b0;
   logic [AW-1:0]   addr = '0;
   logic [BW-1:0]   wdata = '0;
   logic [BW-1:0]   rdata;
   logic            irq_out;

   always #4 clk = ~clk;   // 125 MHz

   evt_irq_hub #(.NUM_BANKS(NB), .BANK_W(BW), .ADDR_W(AW)) uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (evt_in),
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .rdata   (rdata),
      .irq_out (irq_out)
   );

   typedef struct {
      bit        is_irq;
      logic [3:0] a;
      logic [7:0] exp;
      string     req;
   } item_t;

   item_t sb_q[$];
   int    n_vec = 0;
   int    n_bad = 0;
   bit    finished = 0;

   // Monitor: compare after each rising edge, away from the edge.
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (sb_q.size() > 0) begin
            item_t it;
            logic [7:0] act;
            it  = sb_q.pop_front();
            act = it.is_irq ? {7'b0, irq_out} : rdata;
            n_vec++;
            if (act !== it.exp) begin
               n_bad++;
               if (it.is_irq)
                  $display("FAIL %s: irq_out got %0h expected %0h", it.req, act, it.exp);
               else
                  $display("FAIL %s: addr %0d got %02h expected %02h", it.req, it.a, act, it.exp);
            end
         end
      end
   end

   task automatic rd(input logic [3:0] a, input logic [7:0] e, input string r);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0;
      addr  = a;
      it.is_irq = 0; it.a = a; it.exp = e; it.req = r;
      sb_q.push_back(it);
   endtask

   task automatic chk_irq(input logic e, input string r);
      item_t it;
      @(negedge clk);
      wr_en = 1'b0;
      it.is_irq = 1; it.a = '0; it.exp = {7'b0, e}; it.req = r;
      sb_q.push_back(it);
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int src);
      @(negedge clk);
      evt_in[src] = 1'b1;
      @(negedge clk);
      evt_in[src] = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
   endtask

   // Watchdog
   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: run did not finish, got hang expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      idle(3);
      @(negedge clk) rst_n = 1'b1;

      // R1 reset state
      for (int a = 0; a < 3; a++) rd(4'(a), 8'h00, "R1");
      for (int a = 3; a < 9; a++) rd(4'(a), 8'hFF, "R1");
      chk_irq(1'b0, "R1");

      // R2 unmapped reads
      rd(4'd9, 8'h00, "R2");
      rd(4'd15, 8'h00, "R2");

      // R10 unmapped and status writes
      wr(4'd12, 8'h5A);
      rd(4'd3, 8'hFF, "R10");
      rd(4'd6, 8'hFF, "R10");
      wr(4'd0, 8'hFF);
      rd(4'd0, 8'h00, "R10");

      // R3 capture-masked edge ignored
      pulse(3);
      rd(4'd0, 8'h00, "R3");
      chk_irq(1'b0, "R3");

      // R4 capture with line mask still set; R5 no interrupt
      wr(4'd6, 8'h00);
      pulse(3);
      rd(4'd0, 8'h08, "R4");
      chk_irq(1'b0, "R5");

      // R6 unmask line
      wr(4'd3, 8'hF7);
      chk_irq(1'b1, "R6");
      wr(4'd3, 8'hFF);
      chk_irq(1'b0, "R5");
      wr(4'd3, 8'hF7);
      chk_irq(1'b1, "R6");
      wr(4'd6, 8'h08);
      chk_irq(1'b0, "R6");
      rd(4'd0, 8'h08, "R6");
      wr(4'd6, 8'h00);
      chk_irq(1'b1, "R6");

      // R7 write-one-to-clear
      wr(4'd0, 8'h00);
      rd(4'd0, 8'h08, "R7");
      wr(4'd0, 8'hF7);
      rd(4'd0, 8'h08, "R7");
      wr(4'd0, 8'h08);
      rd(4'd0, 8'h00, "R7");
      chk_irq(1'b0, "R7");

      // R2 bank mapping: source 9 -> bank 1 bit 1, source 23 -> bank 2 bit 7
      wr(4'd7, 8'h00);
      wr(4'd8, 8'h00);
      pulse(9);
      pulse(23);
      rd(4'd0, 8'h00, "R2");
      rd(4'd1, 8'h02, "R2");
      rd(4'd2, 8'h80, "R2");
      chk_irq(1'b0, "R5");
      wr(4'd5, 8'h7F);
      chk_irq(1'b1, "R2");
      wr(4'd2, 8'h80);
      chk_irq(1'b0, "R7");
      rd(4'd1, 8'h02, "R7");
      wr(4'd1, 8'h02);
      rd(4'd1, 8'h00, "R7");

      // R9 held-high source recorded once
      @(negedge clk) evt_in[16] = 1'b1;
      idle(2);
      rd(4'd2, 8'h01, "R9");
      wr(4'd2, 8'h01);
      idle(3);
      rd(4'd2, 8'h00, "R9");
      @(negedge clk) evt_in[16] = 1'b0;

      // R8 edge and clear in the same cycle: set wins
      pulse(17);
      rd(4'd2, 8'h02, "R8");
      @(negedge clk);
      evt_in[17] = 1'b1; wr_en = 1'b1; addr = 4'd2; wdata = 8'h02;
      @(negedge clk);
      evt_in[17] = 1'b0; wr_en = 1'b0;
      rd(4'd2, 8'h02, "R8");
      wr(4'd2, 8'h02);
      rd(4'd2, 8'h00, "R7");
      chk_irq(1'b0, "R6");

      idle(3);
      finished = 1;
      summary();
      $finish;
   end

endmodule